// File: doc/BRIEF.md
# Burst Address Generator with Rewind

This block produces the word address that one port of a dual-ported memory uses. It is built for a 14-bit space of 16K words. On every rising clock edge it does one of four things. It can take a new start address from the bus, step the current address up by one, keep the current address, or jump back to the start address taken most recently. A burst master loads a start address once and then steps through consecutive words without driving the address again. With the rewind control it can replay the same burst as often as it needs.

Three active-low controls pick the operation: a strobe, a step enable and a rewind. Rewind outranks the other two, and the strobe outranks the step enable. The block keeps a second register that holds the last start address taken from the bus, which is what rewind returns to. A sleep input freezes both registers. The address output comes straight from the counter register, so it shows the result of an edge from that edge until the next one.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_n` is low, `addr_o` is 0 and the stored start address is 0. A rewind as the first operation after reset gives `addr_o` = 0.
- R2: On an edge with `sleep_i` = 0, `rewind_n` = 1 and `strobe_n` = 0, `addr_o` takes the value of `ext_addr`, whatever `step_n` is.
- R3: On an edge with `sleep_i` = 0, `rewind_n` = 1, `strobe_n` = 1 and `step_n` = 0, `addr_o` becomes its previous value plus one.
- R4: Stepping from the highest address, 0x3FFF, gives 0x0000.
- R5: On an edge with `sleep_i` = 0 and `rewind_n`, `strobe_n` and `step_n` all 1, `addr_o` keeps its value and `ext_addr` is ignored.
- R6: On an edge with `sleep_i` = 0 and `rewind_n` = 0, `addr_o` becomes the stored start address, whatever `strobe_n`, `step_n` and `ext_addr` are.
- R7: Only a load as described in R2 changes the stored start address. Stepping, holding and rewinding leave it unchanged, so a rewind returns to the most recent load.
- R8: On an edge with `sleep_i` = 1, neither `addr_o` nor the stored start address changes, whatever the other controls are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep_i | input | 1 | High to freeze all state |
| strobe_n | input | 1 | Active-low load of `ext_addr` |
| step_n | input | 1 | Active-low increment |
| rewind_n | input | 1 | Active-low return to the stored start address; highest priority |
| ext_addr | input | 14 | Address from the bus |
| addr_o | output | 14 | Address used by the memory array |

## Verification
Assertions in the register module check every cycle that load, step, hold, rewind and sleep each give the next address their requirement defines, with a step from 0x3FFF giving 0x0000. They also check that the stored start address changes only on a load. The bench's scenarios are the only way to show, at the ports, that a rewind lands on the most recent of several loads. They also show that a load attempted during sleep leaves no trace in a later rewind, and that the reset value reaches the output through the rewind path.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

    // operation chosen for the coming edge
    typedef enum logic [2:0] {
        OP_FREEZE = 3'd0,
        OP_KEEP   = 3'd1,
        OP_LOAD   = 3'd2,
        OP_STEP   = 3'd3,
        OP_REWIND = 3'd4
    } addr_op_t;

endpackage

// File: rtl/burst_addr_decode.sv
module burst_addr_decode
    import burst_addr_pkg::*;
(
    input  logic     sleep_i,
    input  logic     strobe_n,
    input  logic     step_n,
    input  logic     rewind_n,
    output addr_op_t op_o
);

    // priority: sleep, then rewind, then strobe, then step
    always_comb begin
        if (sleep_i)
            op_o = OP_FREEZE;
        else if (!rewind_n)
            op_o = OP_REWIND;
        else if (!strobe_n)
            op_o = OP_LOAD;
        else if (!step_n)
            op_o = OP_STEP;
        else
            op_o = OP_KEEP;
    end

endmodule

// File: rtl/burst_addr_regs.sv
module burst_addr_regs
    import burst_addr_pkg::*;
#(
    parameter int AW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  addr_op_t      op_i,
    input  logic [AW-1:0] ext_addr,
    output logic [AW-1:0] addr_o,
    output logic [AW-1:0] start_o
);

    localparam logic [AW-1:0] ONE  = AW'(1);
    localparam logic [AW-1:0] ZERO = '0;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [AW-1:0] start;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (op_i)
            OP_LOAD: begin
                st_d.addr  = ext_addr;
                st_d.start = ext_addr;
            end
            OP_STEP:   st_d.addr = st_q.addr + ONE;
            OP_REWIND: st_d.addr = st_q.start;
            default:   st_d = st_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '{addr: ZERO, start: ZERO};
        else
            st_q <= st_d;
    end

    assign addr_o  = st_q.addr;
    assign start_o = st_q.start;

    // R2
    load_takes_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OP_LOAD |=> addr_o == $past(ext_addr));

    // R3
    step_adds_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_STEP && addr_o != {AW{1'b1}}) |=> addr_o == $past(addr_o) + ONE);

    // R4
    step_wraps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_STEP && addr_o == {AW{1'b1}}) |=> addr_o == ZERO);

    // R5
    keep_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OP_KEEP |=> $stable(addr_o));

    // R6
    rewind_returns_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OP_REWIND |=> addr_o == $past(start_o));

    // R7
    start_only_on_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_i != OP_LOAD |=> $stable(start_o));

    // R8
    sleep_freezes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OP_FREEZE |=> ($stable(addr_o) && $stable(start_o)));

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_addr_pkg::*;
#(
    parameter int AW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sleep_i,
    input  logic          strobe_n,
    input  logic          step_n,
    input  logic          rewind_n,
    input  logic [AW-1:0] ext_addr,
    output logic [AW-1:0] addr_o
);

    addr_op_t      op;
    logic [AW-1:0] start_addr;

    burst_addr_decode u_dec (
        .sleep_i  (sleep_i),
        .strobe_n (strobe_n),
        .step_n   (step_n),
        .rewind_n (rewind_n),
        .op_o     (op)
    );

    burst_addr_regs #(.AW(AW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_i     (op),
        .ext_addr (ext_addr),
        .addr_o   (addr_o),
        .start_o  (start_addr)
    );

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        !rst_n |-> (addr_o == '0 && start_addr == '0));

endmodule

// File: tb/sim_burst_addr_gen.sv
module sim_burst_addr_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sleep_i = 1'b0;
    logic        strobe_n = 1'b1;
    logic        step_n = 1'b1;
    logic        rewind_n = 1'b1;
    logic [13:0] ext_addr = '0;
    logic [13:0] addr_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    burst_addr_gen u0 (
        .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .strobe_n(strobe_n),
        .step_n(step_n), .rewind_n(rewind_n), .ext_addr(ext_addr), .addr_o(addr_o)
    );

    task automatic check(input string req, input logic [13:0] exp);
        n_run++;
        if (addr_o !== exp) begin
            n_fail++;
            $display("FAIL %s addr_o=%h expected=%h", req, addr_o, exp);
        end
    endtask

    // drive at the falling edge, clock once, sample at the next falling edge
    task automatic cyc(input logic slp, input logic stb, input logic stp,
                       input logic rwd, input logic [13:0] a);
        sleep_i = slp; strobe_n = stb; step_n = stp; rewind_n = rwd; ext_addr = a;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        check("R1", 14'h0000);
        cyc(0, 1, 1, 0, 14'h2A2A);
        check("R1", 14'h0000);
    endtask

    task automatic t_load_step;
        cyc(0, 0, 0, 1, 14'h1234);
        check("R2", 14'h1234);
        cyc(0, 1, 0, 1, 14'h0F0F);
        check("R3", 14'h1235);
        cyc(0, 1, 0, 1, 14'h0F0F);
        cyc(0, 1, 0, 1, 14'h0F0F);
        check("R3", 14'h1237);
    endtask

    task automatic t_hold;
        cyc(0, 1, 1, 1, 14'h3333);
        check("R5", 14'h1237);
        cyc(0, 1, 1, 1, 14'h0001);
        check("R5", 14'h1237);
    endtask

    task automatic t_rewind;
        cyc(0, 0, 0, 0, 14'h0555);
        check("R6", 14'h1234);
        cyc(0, 1, 0, 1, 14'h0);
        cyc(0, 1, 1, 0, 14'h0);
        check("R7", 14'h1234);
    endtask

    task automatic t_wrap;
        cyc(0, 0, 1, 1, 14'h3FFE);
        cyc(0, 1, 0, 1, 14'h0);
        check("R3", 14'h3FFF);
        cyc(0, 1, 0, 1, 14'h0);
        check("R4", 14'h0000);
        cyc(0, 1, 1, 0, 14'h0);
        check("R6", 14'h3FFE);
    endtask

    task automatic t_latest_load;
        cyc(0, 0, 1, 1, 14'h0100);
        cyc(0, 0, 1, 1, 14'h0200);
        cyc(0, 1, 0, 1, 14'h0);
        cyc(0, 1, 0, 1, 14'h0);
        check("R3", 14'h0202);
        cyc(0, 1, 1, 0, 14'h0);
        check("R7", 14'h0200);
    endtask

    task automatic t_sleep;
        cyc(0, 1, 0, 1, 14'h0);
        check("R3", 14'h0201);
        cyc(1, 0, 1, 1, 14'h0AAA);
        check("R8", 14'h0201);
        cyc(1, 1, 0, 1, 14'h0);
        check("R8", 14'h0201);
        cyc(1, 1, 1, 0, 14'h0);
        check("R8", 14'h0201);
        cyc(0, 1, 1, 0, 14'h0);
        check("R8", 14'h0200);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_pre();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load_step();
        t_hold();
        t_rewind();
        t_wrap();
        t_latest_load();
        t_sleep();
        done = 1'b1;
    end

    task automatic t_reset_pre;
        check("R1", 14'h0000);
    endtask

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule